// File: doc/BRIEF.md
# Deferred Write-Protect and Activity Indicator Controller

This block sits beside the data path of a flash storage bridge. It watches an asynchronous, active-low protection switch and decides when the flash devices may be locked against writes. The host-visible protected status, a veto on configuration-area writes and a hold on new transfer starts all follow the switch as soon as it has been synchronized. The flash write-protect pin is the exception. It is asserted only once no transfer is in flight and no internal operation is pending, so an operation that has already started is never cut short.

Releasing the switch works in the same way. All protection outputs drop together on the first cycle in which the core is idle.

The block also drives two open-drain style indicators, one for data activity and one for chip readiness. Each is modelled as a constant-low data output with a separate output enable. A low enable means the pin floats.

Top module: `wp_activity_ctrl`

## Requirements
- R1: After reset, flash_wp_n_o is 1, wp_status_o, cfg_wr_block_o and xfer_hold_o are 0, and both indicator enables are 0.
- R2: With transfer and pending flags low, a low level on wp_sw_n_i sets wp_status_o, cfg_wr_block_o and xfer_hold_o to 1 and flash_wp_n_o to 0 at the third rising clock edge after the change. At the second edge they are still unchanged.
- R3: While xfer_active_i or op_pending_i is 1, flash_wp_n_o does not fall. It falls at the first edge that samples both flags low while the synchronized switch is low.
- R4: During the deferral window, wp_status_o, cfg_wr_block_o and xfer_hold_o are already 1 while flash_wp_n_o is still 1.
- R5: When wp_sw_n_i returns high, wp_status_o, cfg_wr_block_o, xfer_hold_o and flash_wp_n_o keep their protected values while the core is busy. They release together at the first edge that samples both flags low, and no earlier than the third edge after the switch change.
- R6: act_led_oe_o equals xfer_active_i as sampled at the previous rising edge, so the indicator is driven while a transfer runs and floats otherwise. act_led_o is always 0.
- R7: chip_led_oe_o equals init_done_i as sampled at the previous rising edge, and chip_led_o is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_sw_n_i | input | 1 | Asynchronous protection switch, low = protect |
| xfer_active_i | input | 1 | A data transfer is in flight |
| op_pending_i | input | 1 | An internal flash operation is pending |
| init_done_i | input | 1 | Device powered and initialized |
| flash_wp_n_o | output | 1 | Write-protect to flash devices, active low |
| wp_status_o | output | 1 | Write-protected status for host reporting |
| cfg_wr_block_o | output | 1 | Veto on configuration-area writes |
| xfer_hold_o | output | 1 | Veto on starting new transfers |
| act_led_o | output | 1 | Data-activity indicator data (constant 0) |
| act_led_oe_o | output | 1 | Data-activity indicator drive enable |
| chip_led_o | output | 1 | Chip-active indicator data (constant 0) |
| chip_led_oe_o | output | 1 | Chip-active indicator drive enable |

## Verification
A switch change passes two synchronizer flops and then one state register. Switch-driven results are therefore due at the third rising edge after the input moves. Busy and idle flags, and the indicator inputs, take effect at the very next edge. The bench changes inputs 1 ns after an edge and samples 1 ns after an edge. For switch changes it checks one edge early to confirm the output has not yet moved, and then at the due edge.

// File: rtl/wpa_pkg.sv
package wpa_pkg;
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic status;   // media reported protected
        logic locked;   // flash write-protect asserted
    } wp_state_t;

    typedef struct packed {
        logic act_oe;
        logic chip_oe;
    } led_state_t;
endpackage

// File: rtl/wpa_sync.sv
module wpa_sync #(
    parameter int    STAGES    = 2,
    parameter logic  RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/wpa_wp_ctrl.sv
module wpa_wp_ctrl
    import wpa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_prot_i,
    input  logic xfer_active_i,
    input  logic op_pending_i,
    output logic status_o,
    output logic locked_o
);
    wp_state_t st_d, st_q;
    logic      idle;

    always_comb begin
        idle = !xfer_active_i && !op_pending_i;
        st_d = st_q;
        if (sw_prot_i) begin
            st_d.status = 1'b1;
        end else if (idle) begin
            st_d.status = 1'b0;
        end
        if (idle) begin
            st_d.locked = sw_prot_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign locked_o = st_q.locked;

    assert_defer_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((xfer_active_i || op_pending_i) && !st_q.locked) |=> !st_q.locked);

    assert_hold_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((xfer_active_i || op_pending_i) && st_q.locked) |=> st_q.locked);

    assert_lock_implies_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked |-> st_q.status);

    assert_status_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((xfer_active_i || op_pending_i) && st_q.status) |=> st_q.status);
endmodule

// File: rtl/wpa_led_ctrl.sv
module wpa_led_ctrl
    import wpa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_active_i,
    input  logic init_done_i,
    output logic act_oe_o,
    output logic chip_oe_o
);
    led_state_t led_d, led_q;

    always_comb begin
        led_d         = led_q;
        led_d.act_oe  = xfer_active_i;
        led_d.chip_oe = init_done_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) led_q <= '0;
        else        led_q <= led_d;
    end

    assign act_oe_o  = led_q.act_oe;
    assign chip_oe_o = led_q.chip_oe;

    assert_act_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_active_i) |=> led_q.act_oe);

    assert_act_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_active_i) |=> !led_q.act_oe);

    assert_chip_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done_i) |=> led_q.chip_oe);
endmodule

// File: rtl/wp_activity_ctrl.sv
module wp_activity_ctrl
    import wpa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wp_sw_n_i,
    input  logic xfer_active_i,
    input  logic op_pending_i,
    input  logic init_done_i,
    output logic flash_wp_n_o,
    output logic wp_status_o,
    output logic cfg_wr_block_o,
    output logic xfer_hold_o,
    output logic act_led_o,
    output logic act_led_oe_o,
    output logic chip_led_o,
    output logic chip_led_oe_o
);
    logic sw_sync_n;
    logic status;
    logic locked;

    wpa_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (wp_sw_n_i),
        .sync_o  (sw_sync_n)
    );

    wpa_wp_ctrl u_wp (
        .clk           (clk),
        .rst_n         (rst_n),
        .sw_prot_i     (!sw_sync_n),
        .xfer_active_i (xfer_active_i),
        .op_pending_i  (op_pending_i),
        .status_o      (status),
        .locked_o      (locked)
    );

    wpa_led_ctrl u_led (
        .clk           (clk),
        .rst_n         (rst_n),
        .xfer_active_i (xfer_active_i),
        .init_done_i   (init_done_i),
        .act_oe_o      (act_led_oe_o),
        .chip_oe_o     (chip_led_oe_o)
    );

    assign flash_wp_n_o   = !locked;
    assign wp_status_o    = status;
    assign cfg_wr_block_o = status;
    assign xfer_hold_o    = status;
    assign act_led_o      = 1'b0;
    assign chip_led_o     = 1'b0;

    assert_sync_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_sync_n && !xfer_active_i && !op_pending_i) |=> !flash_wp_n_o);
endmodule

// File: tb/wp_activity_ctrl_tb_top.sv
module wp_activity_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wp_sw_n = 1'b1;
    logic xfer = 1'b0;
    logic pend = 1'b0;
    logic init_done = 1'b0;
    logic flash_wp_n, wp_status, cfg_blk, hold, act_led, act_oe, chip_led, chip_oe;
    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    wp_activity_ctrl dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .wp_sw_n_i      (wp_sw_n),
        .xfer_active_i  (xfer),
        .op_pending_i   (pend),
        .init_done_i    (init_done),
        .flash_wp_n_o   (flash_wp_n),
        .wp_status_o    (wp_status),
        .cfg_wr_block_o (cfg_blk),
        .xfer_hold_o    (hold),
        .act_led_o      (act_led),
        .act_led_oe_o   (act_oe),
        .chip_led_o     (chip_led),
        .chip_led_oe_o  (chip_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    task automatic check_prot(input logic on, input string req);
        check(wp_status, on, {req, " wp_status"});
        check(cfg_blk, on, {req, " cfg_wr_block"});
        check(hold, on, {req, " xfer_hold"});
    endtask

    task automatic t_reset;
        check(flash_wp_n, 1'b1, "R1 flash_wp_n");
        check_prot(1'b0, "R1");
        check(act_oe, 1'b0, "R1 act_oe");
        check(chip_oe, 1'b0, "R1 chip_oe");
    endtask

    task automatic t_idle_cycle;
        wp_sw_n = 1'b0;
        tick(2);
        check_prot(1'b0, "R2 early");
        check(flash_wp_n, 1'b1, "R2 early flash_wp_n");
        tick(1);
        check_prot(1'b1, "R2 due");
        check(flash_wp_n, 1'b0, "R2 due flash_wp_n");
        wp_sw_n = 1'b1;
        tick(2);
        check_prot(1'b1, "R5 early");
        check(flash_wp_n, 1'b0, "R5 early flash_wp_n");
        tick(1);
        check_prot(1'b0, "R5 due");
        check(flash_wp_n, 1'b1, "R5 due flash_wp_n");
    endtask

    task automatic t_deferred;
        xfer = 1'b1;
        tick(1);
        wp_sw_n = 1'b0;
        tick(3);
        check_prot(1'b1, "R4 deferred");
        check(flash_wp_n, 1'b1, "R4 deferred flash_wp_n");
        tick(5);
        check(flash_wp_n, 1'b1, "R3 held by transfer");
        xfer = 1'b0;
        pend = 1'b1;
        tick(2);
        check(flash_wp_n, 1'b1, "R3 held by pending op");
        pend = 1'b0;
        tick(1);
        check(flash_wp_n, 1'b0, "R3 lock after drain");
    endtask

    task automatic t_release_busy;
        pend = 1'b1;
        wp_sw_n = 1'b1;
        tick(4);
        check_prot(1'b1, "R5 busy");
        check(flash_wp_n, 1'b0, "R5 busy flash_wp_n");
        pend = 1'b0;
        tick(1);
        check_prot(1'b0, "R5 idle");
        check(flash_wp_n, 1'b1, "R5 idle flash_wp_n");
    endtask

    task automatic t_leds;
        xfer = 1'b1;
        check(act_oe, 1'b0, "R6 before edge");
        tick(1);
        check(act_oe, 1'b1, "R6 act driven");
        check(act_led, 1'b0, "R6 act data");
        xfer = 1'b0;
        tick(1);
        check(act_oe, 1'b0, "R6 act float");
        init_done = 1'b1;
        tick(1);
        check(chip_oe, 1'b1, "R7 chip driven");
        check(chip_led, 1'b0, "R7 chip data");
        init_done = 1'b0;
        tick(1);
        check(chip_oe, 1'b0, "R7 chip float");
    endtask

    initial begin
        fork
            begin
                tick(3);
                t_reset;
                rst_n = 1'b1;
                tick(2);
                t_reset;
                t_idle_cycle;
                t_deferred;
                t_release_busy;
                t_leds;
            end
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule